// File: doc/BRIEF.md
# Double-Buffered Slice Configuration Controller

This block holds the configuration bits of a reconfigurable compute fabric that is split into independently reconfigurable slices. Every slice owns two planes of configuration storage. The foreground plane drives the slice datapath through a wide output vector. The shadow plane is filled from a word-wide configuration stream while the foreground plane keeps running. When a slice is asked to swap, its complete shadow plane is copied into the foreground plane on a single clock edge. The other slices are not affected.

A load goes to one slice at a time. The first word accepted while the loader is idle names the target slice on `cfg_slice`. After that, a word counter steers the remaining words into consecutive word positions of that slice's shadow plane. Once the last word is stored, the slice's shadow-ready flag rises. A swap is then allowed. Software can therefore preload the next algorithm for a slice while the current one runs, and switch between them back to back.

Each slice plane holds `TILES_PER_SLICE` tiles of `WORDS_PER_TILE` words. Word k of a slice sits at bits `[k*WORD_W +: WORD_W]` of that slice's field, and the field for slice s sits at bits `[s*SLICE_BITS +: SLICE_BITS]` of `act_cfg`.

The stream loader is a state machine with three states:
- `LD_IDLE` goes to `LD_STREAM` when the first word is accepted. It goes straight to `LD_CLOSE` when a plane holds only one word.
- `LD_STREAM` goes to `LD_CLOSE` when the final word is accepted.
- `LD_CLOSE` always goes back to `LD_IDLE`.

Each slice runs its own state machine with three states:
- `SL_EMPTY` goes to `SL_ARMED` when a load to the slice completes. It goes to `SL_DEFER` when the load completes with a swap request in the same cycle.
- `SL_ARMED` goes to `SL_EMPTY` when a swap promotes the plane, or when a new load to the slice begins.
- `SL_DEFER` promotes the plane and goes to `SL_EMPTY` on the next edge.

Top module: `slice_cfg_ctrl`

## Requirements
- R1: After reset:
  - every bit of `act_cfg` is 0;
  - `bg_ready`, `swap_err` and `load_busy` are 0;
  - `cfg_ready` is 1.
- R2: Routing of a load:
  - The word accepted while the loader is idle selects the target slice from `cfg_slice` and is stored as word 0.
  - The next WORDS-1 accepted words go to word positions 1, 2, and so on, of that same slice, whatever `cfg_slice` then carries.
  - `load_busy` is 1 from after the first word until the final word.
- R3: Writing any shadow plane never changes any bit of `act_cfg`. A slice's foreground bits change only on the edge of its own swap.
- R4: A swap request on a slice whose `bg_ready` bit is 1 copies its full shadow plane into its `act_cfg` field on the edge that samples the request. It clears that `bg_ready` bit on the same edge.
- R5: A swap request on a slice whose `bg_ready` bit is 0 and which is not completing a load leaves its `act_cfg` field unchanged. It raises that slice's `swap_err` bit for exactly the one cycle after the edge that samples the request.
- R6: Behaviour at the final word of a load:
  - The edge that accepts the final word sets the target slice's `bg_ready` bit.
  - `cfg_ready` is 0 for the one cycle that follows, so no word is accepted then.
- R7: A swap request on the target slice in the same cycle as the final word is deferred by one cycle. The newly completed plane appears in `act_cfg` on the following edge and never a partial one. `bg_ready` stays 1 during the deferral cycle.
- R8: A swap or load on one slice leaves the `act_cfg` fields of all other slices unchanged. Swap requests on several ready slices in one cycle promote all of them on the same edge.
- R9: Starting a new load on a slice whose `bg_ready` bit is 1 clears that bit on the edge of the first word. A swap in that same cycle still promotes the previous complete plane. A swap after that edge, before the new load ends, is rejected as in R5.
- R10: A swap request on a slice during its deferral cycle is ignored and does not raise `swap_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | A configuration word is offered |
| cfg_ready | output | 1 | The loader accepts a word this cycle |
| cfg_slice | input | SEL_W | Target slice, sampled on the first word of a load only |
| cfg_word | input | WORD_W | Configuration word |
| swap_req | input | NUM_SLICES | Per-slice request to promote the shadow plane |
| act_cfg | output | NUM_SLICES*SLICE_BITS | Foreground configuration of every slice |
| bg_ready | output | NUM_SLICES | Per-slice flag: a complete shadow plane is waiting |
| swap_err | output | NUM_SLICES | One-cycle pulse: a swap was rejected |
| load_busy | output | 1 | A multi-word load is in progress |

## Verification
The hardest situations to reach from the ports are swap requests that land on the exact cycle in which a load begins or ends. The first case is a swap on the final word of a load, which must be deferred. The second is a swap on the first word of an overwriting load, which must still promote the older plane.

The bench reaches both by driving `swap_req` in the same half-cycle slot as the chosen `cfg_word`. It then samples the outputs after each of the next two edges. It also stops a load halfway and requests a swap, which shows that a discarded plane can never be promoted.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

    // Stream loader states.
    typedef enum logic [1:0] {
        LD_IDLE   = 2'd0,
        LD_STREAM = 2'd1,
        LD_CLOSE  = 2'd2
    } ld_state_e;

    // Per-slice shadow-plane states.
    typedef enum logic [1:0] {
        SL_EMPTY = 2'd0,
        SL_ARMED = 2'd1,
        SL_DEFER = 2'd2
    } sl_state_e;

endpackage

// File: rtl/scfg_loader.sv
module scfg_loader
    import scfg_pkg::*;
#(
    parameter int NUM_SLICES = 4,
    parameter int WORDS      = 6,
    parameter int WORD_W     = 16,
    parameter int SEL_W      = 2,
    parameter int ADDR_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [SEL_W-1:0]  cfg_slice,
    input  logic [WORD_W-1:0] cfg_word,
    output logic              cfg_ready,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_slice,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              ld_start,
    output logic              ld_done,
    output logic              busy
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WORDS - 1);

    ld_state_e         state_q, state_d;
    logic [SEL_W-1:0]  tgt_q, tgt_d;
    logic [ADDR_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            tgt_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        tgt_d     = tgt_q;
        cnt_d     = cnt_q;
        cfg_ready = 1'b0;
        wr_en     = 1'b0;
        wr_slice  = tgt_q;
        wr_addr   = cnt_q;
        wr_data   = cfg_word;
        ld_start  = 1'b0;
        ld_done   = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            LD_IDLE: begin
                cfg_ready = 1'b1;
                if (cfg_valid) begin
                    wr_en    = 1'b1;
                    wr_slice = cfg_slice;
                    wr_addr  = '0;
                    ld_start = 1'b1;
                    tgt_d    = cfg_slice;
                    if (WORDS == 1) begin
                        ld_done = 1'b1;
                        cnt_d   = '0;
                        state_d = LD_CLOSE;
                    end else begin
                        cnt_d   = ADDR_W'(1);
                        state_d = LD_STREAM;
                    end
                end
            end
            LD_STREAM: begin
                cfg_ready = 1'b1;
                busy      = 1'b1;
                if (cfg_valid) begin
                    wr_en = 1'b1;
                    if (cnt_q == LAST_ADDR) begin
                        ld_done = 1'b1;
                        cnt_d   = '0;
                        state_d = LD_CLOSE;
                    end else begin
                        cnt_d = cnt_q + ADDR_W'(1);
                    end
                end
            end
            LD_CLOSE: begin
                state_d = LD_IDLE;
            end
            default: begin
                state_d = LD_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/scfg_slice.sv
module scfg_slice
    import scfg_pkg::*;
#(
    parameter int WORDS  = 6,
    parameter int WORD_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic                    ld_start,
    input  logic                    ld_done,
    input  logic                    swap_req,
    output logic [WORDS*WORD_W-1:0] act_cfg,
    output logic                    bg_valid,
    output logic                    swap_err,
    output logic                    pend
);

    localparam int PLANE_BITS = WORDS * WORD_W;

    sl_state_e             state_q, state_d;
    logic [WORD_W-1:0]     bg_q [WORDS];
    logic [PLANE_BITS-1:0] bg_flat;
    logic [PLANE_BITS-1:0] act_q;
    logic                  promote;
    logic                  err_d, err_q;

    // Shadow plane: one register per word
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bg_q[w] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(w))) begin
                bg_q[w] <= wr_data;
            end
        end
        assign bg_flat[w*WORD_W +: WORD_W] = bg_q[w];
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SL_EMPTY;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    // Foreground plane
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (promote) begin
            act_q <= bg_flat;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        promote = 1'b0;
        err_d   = 1'b0;
        unique case (state_q)
            SL_EMPTY: begin
                if (ld_done) begin
                    state_d = swap_req ? SL_DEFER : SL_ARMED;
                end else if (swap_req) begin
                    err_d = 1'b1;
                end
            end
            SL_ARMED: begin
                if (ld_done) begin
                    state_d = swap_req ? SL_DEFER : SL_ARMED;
                end else if (swap_req) begin
                    promote = 1'b1;
                    state_d = SL_EMPTY;
                end else if (ld_start) begin
                    state_d = SL_EMPTY;
                end
            end
            SL_DEFER: begin
                promote = 1'b1;
                state_d = SL_EMPTY;
            end
            default: begin
                state_d = SL_EMPTY;
            end
        endcase
    end

    assign act_cfg  = act_q;
    assign bg_valid = (state_q != SL_EMPTY);
    assign pend     = (state_q == SL_DEFER);
    assign swap_err = err_q;

endmodule

// File: rtl/slice_cfg_ctrl.sv
module slice_cfg_ctrl #(
    parameter int NUM_SLICES      = 4,
    parameter int TILES_PER_SLICE = 3,
    parameter int WORDS_PER_TILE  = 2,
    parameter int WORD_W          = 16,
    parameter int SEL_W           = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
    parameter int SLICE_BITS      = TILES_PER_SLICE * WORDS_PER_TILE * WORD_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_valid,
    output logic                             cfg_ready,
    input  logic [SEL_W-1:0]                 cfg_slice,
    input  logic [WORD_W-1:0]                cfg_word,
    input  logic [NUM_SLICES-1:0]            swap_req,
    output logic [NUM_SLICES*SLICE_BITS-1:0] act_cfg,
    output logic [NUM_SLICES-1:0]            bg_ready,
    output logic [NUM_SLICES-1:0]            swap_err,
    output logic                             load_busy
);

    localparam int WORDS  = TILES_PER_SLICE * WORDS_PER_TILE;
    localparam int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic              wr_en;
    logic [SEL_W-1:0]  wr_slice;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;
    logic              ld_start;
    logic              ld_done;
    logic [NUM_SLICES-1:0] pend_v;

    scfg_loader #(
        .NUM_SLICES (NUM_SLICES),
        .WORDS      (WORDS),
        .WORD_W     (WORD_W),
        .SEL_W      (SEL_W),
        .ADDR_W     (ADDR_W)
    ) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_slice (cfg_slice),
        .cfg_word  (cfg_word),
        .cfg_ready (cfg_ready),
        .wr_en     (wr_en),
        .wr_slice  (wr_slice),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ld_start  (ld_start),
        .ld_done   (ld_done),
        .busy      (load_busy)
    );

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        logic hit;
        assign hit = (wr_slice == SEL_W'(s));

        scfg_slice #(
            .WORDS  (WORDS),
            .WORD_W (WORD_W),
            .ADDR_W (ADDR_W)
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && hit),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .ld_start (ld_start && hit),
            .ld_done  (ld_done && hit),
            .swap_req (swap_req[s]),
            .act_cfg  (act_cfg[s*SLICE_BITS +: SLICE_BITS]),
            .bg_valid (bg_ready[s]),
            .swap_err (swap_err[s]),
            .pend     (pend_v[s])
        );
    end

endmodule

// File: rtl/slice_cfg_ctrl_chk.sv
module slice_cfg_ctrl_chk #(
    parameter int NUM_SLICES = 4,
    parameter int SLICE_BITS = 96,
    parameter int SEL_W      = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             cfg_ready,
    input logic [NUM_SLICES-1:0]            swap_req,
    input logic [NUM_SLICES*SLICE_BITS-1:0] act_cfg,
    input logic [NUM_SLICES-1:0]            bg_ready,
    input logic [NUM_SLICES-1:0]            swap_err,
    input logic                             ld_done,
    input logic [SEL_W-1:0]                 ld_slice,
    input logic [NUM_SLICES-1:0]            pend
);

    // R6: no word is accepted right after a final word
    a_r6_close_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |=> !cfg_ready);

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_chk
        logic done_s;
        assign done_s = ld_done && (ld_slice == SEL_W'(s));

        // R3 / R8: foreground only moves on this slice's own promotion
        a_r3_active_held: assert property (@(posedge clk) disable iff (!rst_n)
            (!swap_req[s] && !pend[s]) |=> $stable(act_cfg[s*SLICE_BITS +: SLICE_BITS]));

        // R4: an accepted swap consumes the shadow plane
        a_r4_swap_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
            (swap_req[s] && bg_ready[s] && !done_s && !pend[s]) |=> !bg_ready[s]);

        // R5: a swap on an empty shadow plane is flagged
        a_r5_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            (swap_req[s] && !bg_ready[s] && !done_s) |=> swap_err[s]);

        // R5 / R10: never an error while a plane is waiting
        a_r5_no_err_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
            bg_ready[s] |=> !swap_err[s]);

        // R7: swap on the final word is deferred
        a_r7_defer_entry: assert property (@(posedge clk) disable iff (!rst_n)
            (swap_req[s] && done_s) |=> (pend[s] && bg_ready[s]));

        // R7: deferral lasts exactly one cycle
        a_r7_defer_exit: assert property (@(posedge clk) disable iff (!rst_n)
            pend[s] |=> (!pend[s] && !bg_ready[s]));
    end

endmodule

bind slice_cfg_ctrl slice_cfg_ctrl_chk #(
    .NUM_SLICES (NUM_SLICES),
    .SLICE_BITS (SLICE_BITS),
    .SEL_W      (SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_ready (cfg_ready),
    .swap_req  (swap_req),
    .act_cfg   (act_cfg),
    .bg_ready  (bg_ready),
    .swap_err  (swap_err),
    .ld_done   (ld_done),
    .ld_slice  (wr_slice),
    .pend      (pend_v)
);

// File: tb/slice_cfg_ctrl_tb.sv
`timescale 1ns/1ps
module slice_cfg_ctrl_tb;

    localparam int NS    = 4;
    localparam int TILES = 3;
    localparam int WPT   = 2;
    localparam int W     = 16;
    localparam int WORDS = TILES * WPT;
    localparam int SB    = WORDS * W;
    localparam int SELW  = 2;
    localparam int LIMIT = 200000;

    typedef struct packed {
        logic [1:0]    sl;
        logic [15:0]   base;
        logic [NS-1:0] mask;
    } vec_t;

    // Table: load slice `sl` with a plane built from `base`, then swap `mask`
    localparam vec_t VECS [6] = '{
        '{2'd0, 16'h1a00, 4'b0001},
        '{2'd1, 16'h2b10, 4'b0010},
        '{2'd2, 16'h3c20, 4'b0110},
        '{2'd3, 16'h4d30, 4'b1000},
        '{2'd0, 16'h5e40, 4'b1001},
        '{2'd1, 16'h6f50, 4'b1111}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_valid;
    logic             cfg_ready;
    logic [SELW-1:0]  cfg_slice;
    logic [W-1:0]     cfg_word;
    logic [NS-1:0]    swap_req;
    logic [NS*SB-1:0] act_cfg;
    logic [NS-1:0]    bg_ready;
    logic [NS-1:0]    swap_err;
    logic             load_busy;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    logic [SB-1:0] exp_act [NS];
    logic [SB-1:0] exp_bg  [NS];
    logic [NS-1:0] exp_bgv;

    always #2 clk = ~clk;

    slice_cfg_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_ready (cfg_ready),
        .cfg_slice (cfg_slice),
        .cfg_word  (cfg_word),
        .swap_req  (swap_req),
        .act_cfg   (act_cfg),
        .bg_ready  (bg_ready),
        .swap_err  (swap_err),
        .load_busy (load_busy)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == LIMIT) begin
            n_fail = n_fail + 1;
            $display("FAIL R2 watchdog: got %0d cycles expected fewer than %0d", cyc, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [W-1:0] wval(input logic [15:0] base, input int k);
        return base ^ W'(k * 16'h1357) ^ W'(k);
    endfunction

    function automatic logic [SB-1:0] act_of(input int s);
        return act_cfg[s*SB +: SB];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [SB-1:0] got, input logic [SB-1:0] exp);
        n_chk = n_chk + 1;
        if (got !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic chk_all_act(input string req);
        for (int s = 0; s < NS; s++) begin
            chk(req, $sformatf("act slice %0d", s), act_of(s), exp_act[s]);
        end
    endtask

    // Send words from..to of a plane for slice s; later words carry a wrong slice index
    task automatic send_words(input int s, input logic [15:0] base, input int from, input int to);
        for (int k = from; k <= to; k++) begin
            cfg_valid = 1'b1;
            cfg_slice = (k == 0) ? SELW'(s) : SELW'((s + 1) % NS);
            cfg_word  = wval(base, k);
            @(negedge clk);
            exp_bg[s][k*W +: W] = wval(base, k);
            if (k == 0) exp_bgv[s] = 1'b0;
            if (k == WORDS - 1) exp_bgv[s] = 1'b1;
            chk_all_act("R3");
            chk("R6", "bg_ready", SB'(bg_ready), SB'(exp_bgv));
            if (k == WORDS - 1) begin
                chk("R6", "cfg_ready after last word", SB'(cfg_ready), SB'(1'b0));
                chk("R2", "load_busy after last word", SB'(load_busy), SB'(1'b0));
            end else begin
                chk("R2", "load_busy mid load", SB'(load_busy), SB'(1'b1));
            end
        end
        cfg_valid = 1'b0;
        if (to == WORDS - 1) begin
            @(negedge clk);
            chk("R6", "cfg_ready back", SB'(cfg_ready), SB'(1'b1));
        end
    endtask

    task automatic do_swap(input logic [NS-1:0] mask);
        logic [NS-1:0] experr;
        experr = '0;
        swap_req = mask;
        @(negedge clk);
        swap_req = '0;
        for (int s = 0; s < NS; s++) begin
            if (mask[s]) begin
                if (exp_bgv[s]) begin
                    exp_act[s] = exp_bg[s];
                    exp_bgv[s] = 1'b0;
                end else begin
                    experr[s] = 1'b1;
                end
            end
        end
        chk_all_act("R2/R4/R8");
        chk("R4", "bg_ready after swap", SB'(bg_ready), SB'(exp_bgv));
        chk("R5", "swap_err pulse", SB'(swap_err), SB'(experr));
        @(negedge clk);
        chk("R5", "swap_err one cycle only", SB'(swap_err), SB'(0));
        chk_all_act("R8");
    endtask

    initial begin
        rst_n     = 1'b0;
        cfg_valid = 1'b0;
        cfg_slice = '0;
        cfg_word  = '0;
        swap_req  = '0;
        exp_bgv   = '0;
        for (int s = 0; s < NS; s++) begin
            exp_act[s] = '0;
            exp_bg[s]  = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_all_act("R1");
        chk("R1", "bg_ready", SB'(bg_ready), SB'(0));
        chk("R1", "swap_err", SB'(swap_err), SB'(0));
        chk("R1", "load_busy", SB'(load_busy), SB'(0));
        chk("R1", "cfg_ready", SB'(cfg_ready), SB'(1'b1));
        @(negedge clk);

        // R5: every slice empty, all swaps rejected
        do_swap(4'b1111);

        // Table walk
        for (int i = 0; i < 6; i++) begin
            send_words(int'(VECS[i].sl), VECS[i].base, 0, WORDS - 1);
            do_swap(VECS[i].mask);
        end

        // R8: two ready slices promoted on one edge
        send_words(0, 16'h7a61, 0, WORDS - 1);
        send_words(2, 16'h8b72, 0, WORDS - 1);
        do_swap(4'b0101);

        // R7 / R10: swap together with the final word, held high two cycles
        send_words(1, 16'h9c83, 0, WORDS - 2);
        cfg_valid = 1'b1;
        cfg_slice = SELW'(3);
        cfg_word  = wval(16'h9c83, WORDS - 1);
        swap_req  = 4'b0010;
        @(negedge clk);
        cfg_valid = 1'b0;
        exp_bg[1][(WORDS-1)*W +: W] = wval(16'h9c83, WORDS - 1);
        chk_all_act("R7");
        chk("R7", "bg_ready during deferral", SB'(bg_ready[1]), SB'(1'b1));
        chk("R7", "swap_err during deferral", SB'(swap_err), SB'(0));
        @(negedge clk);
        swap_req   = '0;
        exp_act[1] = exp_bg[1];
        exp_bgv[1] = 1'b0;
        chk_all_act("R7");
        chk("R7", "bg_ready after deferred swap", SB'(bg_ready), SB'(exp_bgv));
        chk("R10", "no error for swap in deferral", SB'(swap_err), SB'(0));
        @(negedge clk);
        chk("R10", "still no error", SB'(swap_err), SB'(0));

        // R9: overwrite a ready plane, swap on the first word
        send_words(3, 16'had94, 0, WORDS - 1);
        cfg_valid = 1'b1;
        cfg_slice = SELW'(3);
        cfg_word  = wval(16'hbea5, 0);
        swap_req  = 4'b1000;
        @(negedge clk);
        swap_req   = '0;
        cfg_valid  = 1'b0;
        exp_act[3] = exp_bg[3];
        exp_bg[3][0 +: W] = wval(16'hbea5, 0);
        exp_bgv[3] = 1'b0;
        chk_all_act("R9");
        chk("R9", "bg_ready cleared by new load", SB'(bg_ready), SB'(exp_bgv));
        chk("R9", "swap_err", SB'(swap_err), SB'(0));
        send_words(3, 16'hbea5, 1, 1);
        chk("R2", "load_busy while stalled", SB'(load_busy), SB'(1'b1));
        do_swap(4'b1000);
        send_words(3, 16'hbea5, 2, WORDS - 1);
        do_swap(4'b1000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule